// File: doc/BRIEF.md
# Inter-Port Mailbox Interrupt Unit

This register block connects two processors that share a board. Each of the two ports owns a small bank of 16-bit message words, called mailboxes. The owning port writes and reads its own words. The opposite port can only read them. Software on one side leaves a message in a word and signals the other side by writing the word's upper byte. The receiving side sees an active-low interrupt. It reads the word's upper byte, which both fetches the message and acknowledges it.

A per-port mask decides which sources may drive the interrupt pin. A cause register keeps a snapshot of the unmasked sources that fired, and a status register shows every pending source. From these two registers software can tell which mailbox caused the interrupt and which events it has chosen to hide. Accesses are single-cycle register transfers, so the block applies no back-pressure. A read returns its data on the clock edge that accepts it, and the output holds that value until the next accepted read.

Top module: `mbx_unit`

## Requirements
- R1: After reset every mailbox word reads 0x0000, both cause and status read 0, the mask reads 0x000F (all four sources enabled), both interrupt outputs are high, and both read-data outputs are 0x0000.
- R2: A mailbox-mode write to offsets 0 to 3 stores only the byte lanes whose enable is low (upper enable for bits 15:8, lower enable for bits 7:0). A read returns the enabled lanes, with any disabled lane reading zero. The read data appears on the clock edge that accepts the read and holds until the next accepted read.
- R3: Offsets 4 to 7 read mailboxes 0 to 3 of the opposite port. A write to these offsets changes nothing.
- R4: A mailbox access is accepted only when the mailbox select is low and the memory chip enable is high. An access with the select high, or with both signals low, changes no register and leaves the read data unchanged.
- R5: Only the six low address bits are decoded, so the upper address bits have no effect.
- R6: A write that enables the upper byte of a port's own mailbox k sets status bit k of the opposite port. A write to the lower byte only sets nothing.
- R7: A read of offset 4+k that enables the upper byte clears the reading port's status bit k and cause bit k, and leaves the mailbox contents unchanged. A read of the lower byte only clears nothing.
- R8: The mask sits at offset 8, in bits 3:0, and a bit value of 1 enables the matching source. The mask is written through the lower lane. A set event on a masked source updates status but not cause, and a later unmask does not copy pending status into cause.
- R9: Cause reads at offset 9 and status at offset 10, both in bits 3:0. Offsets 11 to 63 read 0x0000.
- R10: A port's interrupt output is low exactly when its cause register is nonzero. It changes on the same edge as the cause register.
- R11: When a set event and a clear event reach the same source in one cycle, the source ends up set. A read in that cycle returns the word as it was before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mb_sel_n | input | 2 | Mailbox select per port, active low (index 0 = left, 1 = right) |
| mem_ce_n | input | 2 | Memory chip enable per port, active low; must be high for a mailbox access |
| rw_n | input | 2 | Per port: 1 = read, 0 = write |
| ub_n | input | 2 | Upper byte enable per port, active low |
| lb_n | input | 2 | Lower byte enable per port, active low |
| addr | input | 2 x 13 | Address per port; only bits 5:0 are decoded |
| wdata | input | 2 x 16 | Write data per port |
| rdata | output | 2 x 16 | Registered read data per port |
| irq_n | output | 2 | Interrupt per port, active low |

## Verification
A wrong mailbox word shows up on the next read of that word, from either port, one edge after the read is accepted. A wrong pending bit, whether stuck, missed or cleared by a lower-byte read, shows at the interrupt output on the edge after the event that caused it, and the bench checks the output there after every access. Mask and snapshot errors are caught by reading cause and status separately after masked events and after an unmask. A wrong priority between set and clear leaves the interrupt high after the collision, which the bench sees on the very next edge.

// File: rtl/mbx_pkg.sv
`timescale 1ns/1ps
package mbx_pkg;
  // Register region selected by one mailbox-mode access
  typedef enum logic [2:0] {
    RG_NONE,
    RG_OWN,
    RG_PEER,
    RG_MASK,
    RG_CAUSE,
    RG_STAT
  } region_e;
endpackage

// File: rtl/mbx_decode.sv
`timescale 1ns/1ps
module mbx_decode
  import mbx_pkg::*;
#(
  parameter int ADDR_W  = 13,
  parameter int DEC_W   = 6,
  parameter int NUM_BOX = 4,
  parameter int IDX_W   = 2
) (
  input  logic              sel_n,
  input  logic              ce_n,
  input  logic              rw_n,
  input  logic              ub_n,
  input  logic              lb_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              wr,
  output logic              rd,
  output region_e           region,
  output logic [IDX_W-1:0]  idx,
  output logic [1:0]        lane
);
  localparam logic [DEC_W-1:0] PEER_LO = DEC_W'(NUM_BOX);
  localparam logic [DEC_W-1:0] PEER_HI = DEC_W'(2 * NUM_BOX);
  localparam logic [DEC_W-1:0] MASK_AD = DEC_W'(2 * NUM_BOX);
  localparam logic [DEC_W-1:0] CAUS_AD = DEC_W'(2 * NUM_BOX + 1);
  localparam logic [DEC_W-1:0] STAT_AD = DEC_W'(2 * NUM_BOX + 2);

  logic [DEC_W-1:0] off;
  logic             acc;
  logic             unused_hi;

  assign off       = addr[DEC_W-1:0];
  assign unused_hi = ^addr[ADDR_W-1:DEC_W];

  // Mailbox mode needs select low while the memory enable stays off
  assign acc  = !sel_n && ce_n;
  assign wr   = acc && !rw_n;
  assign rd   = acc && rw_n;
  assign lane = {~ub_n, ~lb_n};
  assign idx  = off[IDX_W-1:0];

  always_comb begin
    region = RG_NONE;
    if (off < PEER_LO)       region = RG_OWN;
    else if (off < PEER_HI)  region = RG_PEER;
    else if (off == MASK_AD) region = RG_MASK;
    else if (off == CAUS_AD) region = RG_CAUSE;
    else if (off == STAT_AD) region = RG_STAT;
  end
endmodule

// File: rtl/mbx_store.sv
`timescale 1ns/1ps
module mbx_store #(
  parameter int NUM_BOX = 4,
  parameter int DATA_W  = 16,
  parameter int IDX_W   = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            we,
  input  logic [IDX_W-1:0]                idx,
  input  logic [1:0]                      lane,
  input  logic [DATA_W-1:0]               wdata,
  output logic [NUM_BOX-1:0][DATA_W-1:0]  words,
  output logic [NUM_BOX-1:0]              set_evt
);
  localparam int HALF = DATA_W / 2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      words <= '0;
    end else if (we) begin
      if (lane[0]) words[idx][HALF-1:0]      <= wdata[HALF-1:0];
      if (lane[1]) words[idx][DATA_W-1:HALF] <= wdata[DATA_W-1:HALF];
    end
  end

  // An upper-lane write is the doorbell toward the other side
  always_comb begin
    set_evt = '0;
    if (we && lane[1]) set_evt[idx] = 1'b1;
  end

  AST_STORE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(words)); // R4
endmodule

// File: rtl/mbx_irq.sv
`timescale 1ns/1ps
module mbx_irq #(
  parameter int NUM_BOX = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_BOX-1:0] set_evt,
  input  logic [NUM_BOX-1:0] clr_evt,
  input  logic               mask_we,
  input  logic [NUM_BOX-1:0] mask_wdata,
  output logic [NUM_BOX-1:0] mask_q,
  output logic [NUM_BOX-1:0] status_q,
  output logic [NUM_BOX-1:0] cause_q,
  output logic               irq_n
);
  logic [NUM_BOX-1:0] cause_nx;
  logic [NUM_BOX-1:0] status_nx;

  // Set is applied after clear, so a collision leaves the source pending
  assign status_nx = (status_q & ~clr_evt) | set_evt;
  assign cause_nx  = (cause_q & ~clr_evt) | (set_evt & mask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q   <= '1;
      status_q <= '0;
      cause_q  <= '0;
      irq_n    <= 1'b1;
    end else begin
      if (mask_we) mask_q <= mask_wdata;
      status_q <= status_nx;
      cause_q  <= cause_nx;
      irq_n    <= ~|cause_nx;
    end
  end

  AST_CAUSE_IN_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_q & ~status_q) == '0); // R8

  AST_MASKED_NO_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((cause_q & ~$past(cause_q) & ~$past(mask_q)) == '0)); // R8

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_evt != '0) |=> ((status_q & $past(set_evt)) == $past(set_evt))); // R11

  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_evt & ~set_evt) != '0) |=> ((status_q & $past(clr_evt & ~set_evt)) == '0)); // R7
endmodule

// File: rtl/mbx_unit.sv
`timescale 1ns/1ps
module mbx_unit
  import mbx_pkg::*;
#(
  parameter int NUM_BOX = 4,
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 13,
  parameter int DEC_W   = 6
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [1:0]                   mb_sel_n,
  input  logic [1:0]                   mem_ce_n,
  input  logic [1:0]                   rw_n,
  input  logic [1:0]                   ub_n,
  input  logic [1:0]                   lb_n,
  input  logic [1:0][ADDR_W-1:0]       addr,
  input  logic [1:0][DATA_W-1:0]       wdata,
  output logic [1:0][DATA_W-1:0]       rdata,
  output logic [1:0]                   irq_n
);
  localparam int IDX_W = $clog2(NUM_BOX);
  localparam int NPORT = 2;
  localparam int HALF  = DATA_W / 2;

  logic [NUM_BOX-1:0][DATA_W-1:0] words    [NPORT];
  logic [NUM_BOX-1:0]             set_from [NPORT];

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    localparam int Q = NPORT - 1 - p;

    logic               wr, rd;
    region_e            region;
    logic [IDX_W-1:0]   idx;
    logic [1:0]         lane;
    logic [NUM_BOX-1:0] clr_evt;
    logic [NUM_BOX-1:0] mask_q, status_q, cause_q;
    logic               irq_q;
    logic [DATA_W-1:0]  sel_word, rd_word, rdata_q;

    mbx_decode #(
      .ADDR_W(ADDR_W), .DEC_W(DEC_W), .NUM_BOX(NUM_BOX), .IDX_W(IDX_W)
    ) u_dec (
      .sel_n (mb_sel_n[p]), .ce_n(mem_ce_n[p]), .rw_n(rw_n[p]),
      .ub_n  (ub_n[p]),     .lb_n(lb_n[p]),     .addr(addr[p]),
      .wr    (wr), .rd(rd), .region(region), .idx(idx), .lane(lane)
    );

    mbx_store #(
      .NUM_BOX(NUM_BOX), .DATA_W(DATA_W), .IDX_W(IDX_W)
    ) u_store (
      .clk    (clk), .rst_n(rst_n),
      .we     (wr && region == RG_OWN),
      .idx    (idx), .lane(lane), .wdata(wdata[p]),
      .words  (words[p]), .set_evt(set_from[p])
    );

    // Acknowledge: reading the upper lane of the peer's word k
    always_comb begin
      clr_evt = '0;
      if (rd && region == RG_PEER && lane[1]) clr_evt[idx] = 1'b1;
    end

    mbx_irq #(.NUM_BOX(NUM_BOX)) u_irq (
      .clk        (clk), .rst_n(rst_n),
      .set_evt    (set_from[Q]),
      .clr_evt    (clr_evt),
      .mask_we    (wr && region == RG_MASK && lane[0]),
      .mask_wdata (wdata[p][NUM_BOX-1:0]),
      .mask_q     (mask_q), .status_q(status_q), .cause_q(cause_q),
      .irq_n      (irq_q)
    );

    always_comb begin
      case (region)
        RG_OWN:   sel_word = words[p][idx];
        RG_PEER:  sel_word = words[Q][idx];
        RG_MASK:  sel_word = DATA_W'(mask_q);
        RG_CAUSE: sel_word = DATA_W'(cause_q);
        RG_STAT:  sel_word = DATA_W'(status_q);
        default:  sel_word = '0;
      endcase
    end

    assign rd_word = sel_word & {{HALF{lane[1]}}, {HALF{lane[0]}}};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  rdata_q <= '0;
      else if (rd) rdata_q <= rd_word;
    end

    assign rdata[p] = rdata_q;
    assign irq_n[p] = irq_q;

    AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (!mb_sel_n[p] && !mem_ce_n[p]) |=> $stable(words[p])); // R4

    AST_IDLE_HOLDS_RDATA: assert property (@(posedge clk) disable iff (!rst_n)
      mb_sel_n[p] |=> $stable(rdata[p])); // R4

    AST_IRQ_HAS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_n[p] |-> (status_q != '0)); // R10
  end
endmodule

// File: tb/mbx_unit_bench.sv
`timescale 1ns/1ps
module mbx_unit_bench;
  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [1:0]       mb_sel_n = 2'b11, mem_ce_n = 2'b11, rw_n = 2'b11;
  logic [1:0]       ub_n = 2'b11, lb_n = 2'b11;
  logic [1:0][12:0] addr = '0;
  logic [1:0][15:0] wdata = '0;
  logic [1:0][15:0] rdata;
  logic [1:0]       irq_n;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  done    = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  mbx_unit u_mbx_unit (
    .clk(clk), .rst_n(rst_n), .mb_sel_n(mb_sel_n), .mem_ce_n(mem_ce_n),
    .rw_n(rw_n), .ub_n(ub_n), .lb_n(lb_n), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq_n(irq_n)
  );

  typedef struct packed {
    logic        p;
    logic        sel_n;
    logic        ce_n;
    logic        rw_n;
    logic        ub_n;
    logic        lb_n;
    logic [12:0] ad;
    logic [15:0] wd;
    logic        chk;
    logic [15:0] exp;
    logic [1:0]  irq;   // expected {irq_n[1], irq_n[0]}
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 32;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,13'h000,16'h1234,1'b0,16'h0000,2'b01,4'd6},  // R6 upper write rings right port
    '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,13'h000,16'h0000,1'b1,16'h1234,2'b01,4'd2},  // R2
    '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b1,13'h000,16'h0000,1'b1,16'h1200,2'b01,4'd2},  // R2 upper lane only
    '{1'b1,1'b0,1'b1,1'b1,1'b1,1'b0,13'h004,16'h0000,1'b1,16'h0034,2'b01,4'd7},  // R7 lower read no clear
    '{1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,13'h009,16'h0000,1'b1,16'h0001,2'b01,4'd9},  // R9 cause
    '{1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,13'h00A,16'h0000,1'b1,16'h0001,2'b01,4'd9},  // R9 status
    '{1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,13'h004,16'h0000,1'b1,16'h1234,2'b11,4'd7},  // R7 acknowledge
    '{1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,13'h009,16'h0000,1'b1,16'h0000,2'b11,4'd7},
    '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,13'h000,16'h0000,1'b1,16'h1234,2'b11,4'd7},  // R7 contents kept
    '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,13'h001,16'hABCD,1'b0,16'h0000,2'b11,4'd6},  // R6 lower only
    '{1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,13'h00A,16'h0000,1'b1,16'h0000,2'b11,4'd6},
    '{1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,13'h005,16'h0000,1'b1,16'h00CD,2'b11,4'd3},  // R3 peer read
    '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,13'h005,16'hFFFF,1'b0,16'h0000,2'b11,4'd3},  // R3 peer write ignored
    '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,13'h001,16'h0000,1'b1,16'h00CD,2'b11,4'd3},
    '{1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,13'h008,16'h000D,1'b0,16'h0000,2'b11,4'd8},  // R8 mask source 1
    '{1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,13'h008,16'h0000,1'b1,16'h000D,2'b11,4'd8},
    '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,13'h001,16'h5500,1'b0,16'h0000,2'b11,4'd8},  // R8 masked set
    '{1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,13'h00A,16'h0000,1'b1,16'h0002,2'b11,4'd8},
    '{1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,13'h009,16'h0000,1'b1,16'h0000,2'b11,4'd8},
    '{1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,13'h008,16'h000F,1'b0,16'h0000,2'b11,4'd8},  // R8 unmask
    '{1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,13'h009,16'h0000,1'b1,16'h0000,2'b11,4'd8},  // R8 no copy
    '{1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,13'h005,16'h0000,1'b1,16'h55CD,2'b11,4'd7},
    '{1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,13'h00A,16'h0000,1'b1,16'h0000,2'b11,4'd7},
    '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,13'h1FC3,16'hBEEF,1'b0,16'h0000,2'b10,4'd5}, // R5 high bits set
    '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,13'h0A47,16'h0000,1'b1,16'hBEEF,2'b11,4'd5}, // R5
    '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,13'h009,16'h0000,1'b1,16'h0000,2'b11,4'd7},
    '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,13'h002,16'h1111,1'b0,16'h0000,2'b11,4'd4},  // R4 select off
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,13'h002,16'h2222,1'b0,16'h0000,2'b11,4'd4},  // R4 both low
    '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,13'h000,16'h0000,1'b1,16'h1234,2'b11,4'd4},
    '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,13'h002,16'h0000,1'b1,16'h1234,2'b11,4'd4},  // R4 rdata holds
    '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,13'h002,16'h0000,1'b1,16'h0000,2'b11,4'd4},
    '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,13'h00B,16'h0000,1'b1,16'h0000,2'b11,4'd9}   // R9 unmapped
  };

  task automatic check(input int req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    mb_sel_n = 2'b11; mem_ce_n = 2'b11; rw_n = 2'b11;
    ub_n = 2'b11; lb_n = 2'b11; addr = '0; wdata = '0;
  endtask

  task automatic put(input logic p, input logic s, input logic c, input logic r,
                     input logic u, input logic l, input logic [12:0] a,
                     input logic [15:0] d);
    mb_sel_n[p] = s; mem_ce_n[p] = c; rw_n[p] = r;
    ub_n[p] = u; lb_n[p] = l; addr[p] = a; wdata[p] = d;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(1, "rdata left", rdata[0], 16'h0000);
    check(1, "rdata right", rdata[1], 16'h0000);
    check(1, "irq_n", {14'd0, irq_n}, 16'h0003);
    put(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 13'h008, 16'h0);
    @(negedge clk); idle();
    check(1, "mask reset", rdata[0], 16'h000F);

    for (int i = 0; i < NV; i++) begin
      put(VECS[i].p, VECS[i].sel_n, VECS[i].ce_n, VECS[i].rw_n,
          VECS[i].ub_n, VECS[i].lb_n, VECS[i].ad, VECS[i].wd);
      @(negedge clk); idle();
      if (VECS[i].chk)
        check(int'(VECS[i].req), $sformatf("vec %0d rdata", i),
              rdata[VECS[i].p], VECS[i].exp);
      check(10, $sformatf("vec %0d irq_n", i), {14'd0, irq_n}, {14'd0, VECS[i].irq}); // R10
    end

    // R11: left writes upper byte of box 0 while right acknowledges it
    put(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 13'h000, 16'hAA00);
    put(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 13'h004, 16'h0000);
    @(negedge clk); idle();
    check(11, "collision read old word", rdata[1], 16'h1234);
    check(11, "collision irq_n", {14'd0, irq_n}, 16'h0001);
    put(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 13'h009, 16'h0);
    @(negedge clk); idle();
    check(11, "collision cause", rdata[1], 16'h0001);
    put(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 13'h004, 16'h0);
    @(negedge clk); idle();
    check(7, "ack after collision", rdata[1], 16'hAA34);
    check(10, "irq_n released", {14'd0, irq_n}, 16'h0003);

    // R1 reset in mid run clears storage and mask
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    put(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 13'h000, 16'h0);
    @(negedge clk); idle();
    check(1, "box cleared", rdata[0], 16'h0000);
    put(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 13'h008, 16'h0);
    @(negedge clk); idle();
    check(1, "mask restored", rdata[1], 16'h000F);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule